// File: doc/BRIEF.md
# Masked Vector Add Unit with Density-Time Scheduling

This block runs an elementwise add over one vector register under a per-element mask. The operands come from an outside register file. The unit presents an element index on `rd_idx` and takes both operand elements back in the same cycle. It returns each result on a write port that carries an index, data and an enable. The mask register sits inside the block and has one bit per element. It can be set to all ones, or built from a test that compares each element of the first operand against a scalar.

There are two add modes. The sequential add walks through every element below the vector length. It drives the write enable from that element's mask bit, so a masked-off element passes through the unit as a bubble and its destination stays unchanged. The density-time add scans the mask and spends cycles only on elements whose bit is set. Each of those results is written to the element's own index. A masked-off element therefore costs no cycles in this mode.

A command is given as a one-cycle request with an opcode, a vector length and a scalar. `busy` stays high while the command runs. `done` pulses when it finishes.

Top module: `vmask_unit`

## Requirements
- R1: Synchronous active-high reset clears `busy`, `done` and `wr_en`, and sets every mask bit to 1.
- R2: A command is accepted on a clock edge where `cmd_valid` is high and `busy` is low, and `busy` is high after that edge. A command presented while `busy` is high is ignored and changes neither the mask nor any write.
- R3: Opcode 0 (sequential add) takes vl+1 busy cycles. In run cycle k (k < vl) the write port shows `wr_idx`=k, `wr_data`=(a[k]+b[k]) mod 2^EW and `wr_en`=mask bit k. Indices rise in order.
- R4: Opcode 1 (density-time add) writes, in increasing index order and on consecutive cycles, only the elements whose effective mask bit is 1. Each such write has `wr_en`=1 and `wr_idx` equal to that element's index. It takes (number of set bits)+1 busy cycles, so an all-zero mask finishes in one cycle with no write.
- R5: Mask bits at indices at or above the command's vector length count as 0, so no write ever targets such an index.
- R6: Opcode 2 sets every mask bit to 1 in one busy cycle and performs no write.
- R7: Opcode 3 sets mask bit i to (a[i] > scalar), compared unsigned, for each i below vl, and leaves the bits at or above vl unchanged. It takes vl+1 busy cycles and performs no write.
- R8: `done` is a one-cycle pulse. It comes in the cycle where `busy` has just fallen, one cycle after the last write.
- R9: A `cmd_vlen` above MAXVL is treated as MAXVL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 0 seq add, 1 density add, 2 set mask, 3 compare |
| cmd_vlen | input | VLW | Vector length for the command |
| cmd_scalar | input | EW | Scalar for the compare |
| busy | output | 1 | Command in progress |
| done | output | 1 | Completion pulse |
| rd_idx | output | IW | Element index being read |
| rd_a | input | EW | First operand element at `rd_idx` |
| rd_b | input | EW | Second operand element at `rd_idx` |
| wr_en | output | 1 | Result write enable |
| wr_idx | output | IW | Result element index |
| wr_data | output | EW | Result element value |

## Verification
A bad pending-mask bit in density-time mode shows up within one run cycle. It appears as a skipped or extra write index, and the `done` pulse moves by a cycle. A wrong mask register bit stays hidden until a later add. The bench exposes it by following every compare or set command with both kinds of add over the full length, so a corrupted bit shows up as a wrong `wr_en` or write index within that add's cycles. Any error in the length counting or the ignore-while-busy rule moves the `busy` fall and the `done` pulse, and the per-cycle comparison flags it on the first differing cycle.

// File: rtl/vmask_pkg.sv
package vmask_pkg;
  typedef enum logic [1:0] {
    OP_ADD_SEQ   = 2'd0,
    OP_ADD_DENSE = 2'd1,
    OP_MASK_ALL  = 2'd2,
    OP_MASK_GT   = 2'd3
  } vop_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } vstate_e;
endpackage

// File: rtl/vmask_bank.sv
module vmask_bank #(
  parameter int NEL = 16,
  localparam int IW = (NEL > 1) ? $clog2(NEL) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           set_all,
  input  logic           upd_en,
  input  logic [IW-1:0]  upd_idx,
  input  logic           upd_bit,
  output logic [NEL-1:0] mask
);
  for (genvar g = 0; g < NEL; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                                  mask[g] <= 1'b1;
      else if (set_all)                         mask[g] <= 1'b1;
      else if (upd_en && upd_idx == IW'(g))     mask[g] <= upd_bit;
    end
  end

  assert_set_all_R6: assert property (@(posedge clk) disable iff (rst)
    set_all |=> (&mask));

  assert_cmp_update_R7: assert property (@(posedge clk) disable iff (rst)
    (upd_en && !set_all) |=> (mask[$past(upd_idx)] == $past(upd_bit)));
endmodule

// File: rtl/vmask_lowest.sv
module vmask_lowest #(
  parameter int N = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] pos
);
  always_comb begin
    found = 1'b0;
    pos   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        pos   = IW'(i);
      end
    end
  end

  always_comb begin
    if (found) begin
      assert_pick_hit_R4: assert (vec[pos]);
      assert_pick_lowest_R4: assert ((vec & ((N'(1) << pos) - N'(1))) == '0);
    end
  end
endmodule

// File: rtl/vmask_unit.sv
module vmask_unit
  import vmask_pkg::*;
#(
  parameter int MAXVL = 16,
  parameter int EW    = 16,
  localparam int IW   = (MAXVL > 1) ? $clog2(MAXVL) : 1,
  localparam int VLW  = $clog2(MAXVL + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cmd_valid,
  input  logic [1:0]     cmd_op,
  input  logic [VLW-1:0] cmd_vlen,
  input  logic [EW-1:0]  cmd_scalar,
  output logic           busy,
  output logic           done,
  output logic [IW-1:0]  rd_idx,
  input  logic [EW-1:0]  rd_a,
  input  logic [EW-1:0]  rd_b,
  output logic           wr_en,
  output logic [IW-1:0]  wr_idx,
  output logic [EW-1:0]  wr_data
);
  vstate_e          state_q;
  vop_e             op_q;
  logic [VLW-1:0]   vl_q;
  logic [VLW-1:0]   idx_q;
  logic [EW-1:0]    scal_q;
  logic [MAXVL-1:0] pend_q;

  logic [VLW-1:0]   vl_eff;
  logic [MAXVL-1:0] len_mask;
  logic [MAXVL-1:0] mask;
  logic             accept;
  logic             pick_found;
  logic [IW-1:0]    pick_pos;
  logic             set_all, upd_en, upd_bit;
  logic             seq_end;
  logic [EW-1:0]    sum;

  assign accept  = cmd_valid && (state_q == ST_IDLE);
  assign vl_eff  = (cmd_vlen > VLW'(MAXVL)) ? VLW'(MAXVL) : cmd_vlen;
  assign seq_end = (idx_q == vl_q);
  assign sum     = rd_a + rd_b;
  assign busy    = (state_q == ST_RUN);
  assign rd_idx  = (op_q == OP_ADD_DENSE) ? pick_pos : idx_q[IW-1:0];

  always_comb begin
    for (int i = 0; i < MAXVL; i++) len_mask[i] = (i < int'(vl_eff));
  end

  always_comb begin
    set_all = busy && (op_q == OP_MASK_ALL);
    upd_en  = busy && (op_q == OP_MASK_GT) && !seq_end;
    upd_bit = rd_a > scal_q;
  end

  vmask_bank #(.NEL(MAXVL)) u_bank (
    .clk(clk), .rst(rst), .set_all(set_all), .upd_en(upd_en),
    .upd_idx(idx_q[IW-1:0]), .upd_bit(upd_bit), .mask(mask)
  );

  vmask_lowest #(.N(MAXVL)) u_pick (
    .vec(pend_q), .found(pick_found), .pos(pick_pos)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      op_q    <= OP_ADD_SEQ;
      vl_q    <= '0;
      idx_q   <= '0;
      scal_q  <= '0;
      pend_q  <= '0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
      done    <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      done  <= 1'b0;
      if (accept) begin
        state_q <= ST_RUN;
        op_q    <= vop_e'(cmd_op);
        vl_q    <= vl_eff;
        idx_q   <= '0;
        scal_q  <= cmd_scalar;
        pend_q  <= mask & len_mask;
      end else if (busy) begin
        case (op_q)
          OP_ADD_SEQ, OP_MASK_GT: begin
            if (seq_end) begin
              state_q <= ST_IDLE;
              done    <= 1'b1;
            end else begin
              idx_q <= idx_q + 1'b1;
              if (op_q == OP_ADD_SEQ) begin
                wr_en   <= mask[idx_q[IW-1:0]];
                wr_idx  <= idx_q[IW-1:0];
                wr_data <= sum;
              end
            end
          end
          OP_ADD_DENSE: begin
            if (!pick_found) begin
              state_q <= ST_IDLE;
              done    <= 1'b1;
            end else begin
              wr_en            <= 1'b1;
              wr_idx           <= pick_pos;
              wr_data          <= sum;
              pend_q[pick_pos] <= 1'b0;
            end
          end
          default: begin
            state_q <= ST_IDLE;
            done    <= 1'b1;
          end
        endcase
      end
    end
  end

  assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !busy) |=> busy);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_write_in_len_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ({1'b0, wr_idx} < {1'b0, vl_q}));

  assert_write_order_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(wr_en)) |-> (wr_idx > $past(wr_idx)));

  assert_write_busy_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(busy));
endmodule

// File: tb/test_vmask_unit.sv
module test_vmask_unit;
  localparam int MAXVL = 16;
  localparam int EW    = 16;
  localparam int IW    = $clog2(MAXVL);
  localparam int VLW   = $clog2(MAXVL + 1);

  typedef struct { bit we; int idx; int data; bit dn; } ev_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [VLW-1:0] cmd_vlen = '0;
  logic [EW-1:0] cmd_scalar = '0;
  logic busy, done, wr_en;
  logic [IW-1:0] rd_idx, wr_idx;
  logic [EW-1:0] rd_a, rd_b, wr_data;

  logic [EW-1:0] va [MAXVL];
  logic [EW-1:0] vb [MAXVL];
  bit   mm [MAXVL];
  ev_t  q[$];
  bit   e_we, e_dn, e_busy;
  int   e_idx, e_data;
  int   nchk = 0, nfail = 0;
  bit   wd = 1'b0;
  string tag = "R1";

  assign rd_a = va[rd_idx];
  assign rd_b = vb[rd_idx];

  always #4 clk = ~clk;

  vmask_unit #(.MAXVL(MAXVL), .EW(EW)) i_vmask_unit (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_vlen(cmd_vlen), .cmd_scalar(cmd_scalar), .busy(busy), .done(done),
    .rd_idx(rd_idx), .rd_a(rd_a), .rd_b(rd_b), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data)
  );

  task automatic build(input int op, input int vlen, input int s);
    int vl;
    vl = (vlen > MAXVL) ? MAXVL : vlen;
    case (op)
      0: for (int i = 0; i < vl; i++)
           q.push_back('{mm[i], i, (int'(va[i]) + int'(vb[i])) % (1 << EW), 1'b0});
      1: for (int i = 0; i < vl; i++)
           if (mm[i]) q.push_back('{1'b1, i, (int'(va[i]) + int'(vb[i])) % (1 << EW), 1'b0});
      2: for (int i = 0; i < MAXVL; i++) mm[i] = 1'b1;
      default: for (int i = 0; i < vl; i++) begin
           mm[i] = (int'(va[i]) > s);
           q.push_back('{1'b0, 0, 0, 1'b0});
         end
    endcase
    q.push_back('{1'b0, 0, 0, 1'b1});
  endtask

  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      e_we = 0; e_dn = 0; e_busy = 0; e_idx = 0; e_data = 0;
      for (int i = 0; i < MAXVL; i++) mm[i] = 1'b1;
    end else if (q.size() > 0) begin
      ev_t r;
      r = q.pop_front();
      e_we = r.we; e_idx = r.idx; e_data = r.data; e_dn = r.dn;
      e_busy = (q.size() > 0);
    end else if (cmd_valid) begin
      build(int'(cmd_op), int'(cmd_vlen), int'(cmd_scalar));
      e_we = 0; e_dn = 0; e_busy = 1;
    end else begin
      e_we = 0; e_dn = 0; e_busy = 0;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      nchk++;
      if (busy !== e_busy || done !== e_dn || wr_en !== e_we) begin
        nfail++;
        $display("FAIL %s: busy/done/wr_en = %b%b%b, expected %b%b%b",
                 tag, busy, done, wr_en, e_busy, e_dn, e_we);
      end
      if (e_we) begin
        nchk++;
        if (wr_idx !== IW'(e_idx) || wr_data !== EW'(e_data)) begin
          nfail++;
          $display("FAIL %s: write idx/data = %0d/%h, expected %0d/%h",
                   tag, wr_idx, wr_data, e_idx, EW'(e_data));
        end
      end
    end
  end

  task automatic issue(input int op, input int vlen, input int s, input string t);
    @(negedge clk);
    tag = t;
    cmd_valid = 1'b1; cmd_op = 2'(op); cmd_vlen = VLW'(vlen); cmd_scalar = EW'(s);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (e_busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic fill();
    for (int i = 0; i < MAXVL; i++) begin
      va[i] = EW'($urandom);
      vb[i] = EW'($urandom);
    end
  endtask

  task automatic stimulus();
    fill();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);           // R1: idle outputs after reset
    issue(1, MAXVL, 0, "R1");            // R1: mask all ones -> every element written
    for (int round = 0; round < 6; round++) begin
      fill();
      issue(3, MAXVL, 1 << (EW - 1), "R7");
      issue(0, MAXVL, 0, "R3");
      issue(1, MAXVL, 0, "R4");
    end
    issue(3, MAXVL, (1 << EW) - 1, "R7"); // all bits cleared
    issue(1, MAXVL, 0, "R4");            // R4: empty mask, one cycle
    issue(0, 7, 0, "R3");                // R3: all bubbles
    issue(2, 3, 0, "R6");
    issue(1, MAXVL, 0, "R6");            // R6: all set
    issue(3, 4, (1 << EW) - 1, "R7");    // bits 0..3 cleared, 4.. unchanged
    issue(1, 8, 0, "R7");
    issue(0, 6, 0, "R7");
    issue(2, 0, 0, "R6");
    issue(1, 5, 0, "R5");                // R5: nothing at or above 5
    issue(0, 0, 0, "R5");                // R5: zero length
    issue(1, 0, 0, "R5");
    issue(1, 31, 0, "R9");               // R9: clamp to MAXVL
    issue(3, 31, 1 << (EW - 1), "R9");
    issue(0, 31, 0, "R9");
    va[2] = '1; vb[2] = EW'(2);          // R3: wraparound sum
    issue(0, 4, 0, "R3");
    // R2: command while busy is ignored
    issue(3, MAXVL, 1 << (EW - 2), "R2");
    @(negedge clk);
    tag = "R2";
    cmd_valid = 1'b1; cmd_op = 2'd0; cmd_vlen = VLW'(10); cmd_scalar = '0;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd2;     // ignored set-mask
    @(negedge clk);
    cmd_valid = 1'b0;
    while (e_busy) @(negedge clk);
    @(negedge clk);
    issue(1, MAXVL, 0, "R2");            // R2: mask still from compare
    issue(0, MAXVL, 0, "R8");
    repeat (3) @(negedge clk);
  endtask

  initial begin
    fork
      stimulus();
      begin
        repeat (150000) @(posedge clk);
        wd = 1'b1;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nchk + (wd ? 1 : 0),
             nfail + (wd ? 1 : 0));
    $finish;
  end
endmodule